// File: doc/BRIEF.md
# Clock Generator Control Register Bank with Two-Wire Slave

This block is the configuration front end of a clock generator. It is a slave on a two-wire SMBus and holds a fifteen-byte control register file. The register contents drive the generator's frequency select, spread enable and spread type, the enable and stop behaviour of each of the eight clock outputs, the polarity of the output-enable pins, the divider-programming enable and the reference output enable. Five control bits start from strap pins sampled during reset. After reset, software can take those bits over by setting an override bit.

A host reaches the file with indexed block transfers. A write sends the device write address, a starting index, a byte count and then the data bytes. A read sends the write address and the index, then a repeated start and the read address. The slave answers with the value of its count register and then streams bytes from the index upward until the host declines one. SCL and SDA are oversampled in the system clock domain. The slave pulls SDA low through an output enable and never drives it high.

Top module: `smb_clkgen_regs`

## Requirements
- R1: Address byte 0xDC (write) and 0xDD (read) are ACKed. Any other address byte is NACKed, and the slave then leaves SDA released, NACKing every further byte until the next start.
- R2: In a write, the byte after 0xDC sets the index and the next byte sets the count. Each following data byte, sent MSB first, is ACKed and stored at the current index, and the index then increments.
- R3: Once the count of data bytes in a write is used up, each further data byte is NACKed and is not stored.
- R4: After a repeated start with 0xDD, the slave sends byte 6 (the count register) first and then bytes from the index upward, one per host ACK. After the host NACKs a byte, SDA stays released.
- R5: After reset the bytes read as follows: byte 0 = {strap_fs[3:0], strap_spread, 3'b000}, byte 1 = 0xFF, byte 2 = 0x00, byte 4 = VENDOR_REV (0x01), byte 5 = DEVICE_ID (0x08), byte 6 = 0x07, byte 9 = 0x60, byte 14 = 0x80. All other bytes read 0x00.
- R6: Byte 0 holds freq_sel in bits 7:4, spread enable in bit 3, software override in bit 2, stop drive mode in bit 1 and spread type in bit 0. Bits 2:0 always take a written value. Bits 7:3 take it only if the stored bit 2 was already 1 before that byte was written.
- R7: Byte 3 is read-only and shows the live {strap_fs, strap_spread, 3'b000}. A change of the straps after reset does not alter byte 0.
- R8: Bytes 3, 4, 5, 7, 8 and 14 ignore writes. Bits 4:0 of byte 9 and bit 7 of byte 13 read 0. Bytes 1, 2, 6, 10, 11 and 12 are fully writable.
- R9: Indices above 14 are ACKed. Writes to them are ignored and reads of them return 0x00.
- R10: freq_sel, spread_en, stop_hiz and spread_center reflect byte 0 bits 7:4, 3, 1 and 0. out_en equals byte 1 and stop_able equals byte 2. mn_prog_en, oe_pol and ref_en equal byte 9 bits 7, 6 and 5.
- R11: The slave changes sda_oe only while SCL is low, except when it releases SDA on a start or stop. A stop always leaves SDA released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset; straps are sampled while it is high |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| strap_fs | input | 4 | Frequency-select strap pins |
| strap_spread | input | 1 | Spread-enable strap pin |
| freq_sel | output | 4 | Frequency select code |
| spread_en | output | 1 | Spread spectrum enable |
| spread_center | output | 1 | Spread type: 0 down, 1 center |
| stop_hiz | output | 1 | Stopped outputs: 0 driven, 1 high impedance |
| out_en | output | 8 | Per-output enable, bit n for output n |
| stop_able | output | 8 | Per-output stop mode: 1 stoppable, 0 free-running |
| mn_prog_en | output | 1 | Divider programming enable |
| oe_pol | output | 1 | Output-enable pin polarity: 1 active high |
| ref_en | output | 1 | Reference clock output enable |

## Verification
The hardest case to reach from the ports is the override rule in byte 0. Whether bits 7:3 take a write depends on bit 2 as stored before that byte, so the value that enables the override, written alone, must not itself change the strap-loaded bits. The stimulus writes byte 0 with the override clear, then writes the value that sets it, then writes new strap bits. It also changes the strap pins after reset to show that byte 3 follows them while byte 0 does not. Random block writes with random indices, counts and surplus bytes then exercise the count limit and the out-of-range indices, and full block reads compare all fifteen bytes against a bench model.

// File: rtl/smb_clkgen_pkg.sv
package smb_clkgen_pkg;

    localparam int NUM_REGS = 15;
    localparam int IDX_W    = 8;

    // register positions that the decode and the outputs depend on
    localparam int B_CTL    = 0;
    localparam int B_OUTEN  = 1;
    localparam int B_STOP   = 2;
    localparam int B_STRAP  = 3;
    localparam int B_VREV   = 4;
    localparam int B_DEVID  = 5;
    localparam int B_COUNT  = 6;
    localparam int B_MODE   = 9;
    localparam int B_DIVHI  = 10;
    localparam int B_DIVLO  = 11;
    localparam int B_SSLO   = 12;
    localparam int B_SSHI   = 13;
    localparam int B_TEST   = 14;

    typedef enum logic [2:0] {
        ST_IDLE, ST_ADDR, ST_WDATA, ST_ACK, ST_RDATA, ST_RACK, ST_SKIP
    } smb_state_e;

    typedef enum logic [1:0] {PH_INDEX, PH_COUNT, PH_DATA} wr_phase_e;

    typedef struct packed {
        logic [3:0] freq_sel;
        logic       spread_en;
        logic       sw_ovr;
        logic       stop_hiz;
        logic       spread_center;
    } ctl0_t;

    typedef struct packed {
        logic       mn_prog_en;
        logic       oe_pol;
        logic       ref_en;
        logic [4:0] rsvd;
    } mode_t;

    function automatic logic [7:0] write_mask(int idx);
        case (idx)
            B_CTL, B_OUTEN, B_STOP, B_COUNT, B_DIVHI, B_DIVLO, B_SSLO: return 8'hFF;
            B_MODE: return 8'hE0;
            B_SSHI: return 8'h7F;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [7:0] reset_value(int idx, logic [4:0] straps,
                                               logic [7:0] vrev, logic [7:0] devid);
        case (idx)
            B_CTL:   return {straps, 3'b000};
            B_OUTEN: return 8'hFF;
            B_VREV:  return vrev;
            B_DEVID: return devid;
            B_COUNT: return 8'h07;
            B_MODE:  return 8'h60;
            B_TEST:  return 8'h80;
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic line_i,
    output logic level_o,
    output logic rise_o,
    output logic fall_o
);
    logic [STAGES-1:0] pipe;
    logic              last;

    always_ff @(posedge clk) begin
        if (rst) begin
            pipe <= '1;
            last <= 1'b1;
        end else begin
            pipe <= {pipe[STAGES-2:0], line_i};
            last <= pipe[STAGES-1];
        end
    end

    assign level_o = pipe[STAGES-1];
    assign rise_o  = pipe[STAGES-1] & ~last;
    assign fall_o  = ~pipe[STAGES-1] & last;
endmodule

// File: rtl/smb_proto_engine.sv
module smb_proto_engine
    import smb_clkgen_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h6E
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             scl_lvl,
    input  logic             scl_rise,
    input  logic             scl_fall,
    input  logic             sda_lvl,
    input  logic             sda_rise,
    input  logic             sda_fall,
    input  logic [7:0]       rd_data,
    input  logic [7:0]       cnt_byte,
    output logic             sda_oe,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output logic [7:0]       wr_data,
    output logic [IDX_W-1:0] rd_idx
);
    smb_state_e       state;
    wr_phase_e        phase;
    logic [7:0]       shreg;
    logic [3:0]       bitcnt;
    logic             is_read;
    logic             host_ack;
    logic [IDX_W-1:0] idx;
    logic [7:0]       left;

    logic start_ev, stop_ev;
    assign start_ev = sda_fall & scl_lvl;
    assign stop_ev  = sda_rise & scl_lvl;
    assign rd_idx   = idx;

    always_ff @(posedge clk) begin
        wr_en <= 1'b0;
        if (rst) begin
            state    <= ST_IDLE;
            phase    <= PH_INDEX;
            shreg    <= '0;
            bitcnt   <= '0;
            is_read  <= 1'b0;
            host_ack <= 1'b0;
            idx      <= '0;
            left     <= '0;
            sda_oe   <= 1'b0;
            wr_idx   <= '0;
            wr_data  <= '0;
        end else if (start_ev) begin
            state  <= ST_ADDR;
            phase  <= PH_INDEX;
            bitcnt <= '0;
            sda_oe <= 1'b0;
        end else if (stop_ev) begin
            state  <= ST_IDLE;
            sda_oe <= 1'b0;
        end else begin
            case (state)
                ST_ADDR, ST_WDATA: begin
                    if (scl_rise) begin
                        shreg  <= {shreg[6:0], sda_lvl};
                        bitcnt <= bitcnt + 4'd1;
                    end else if (scl_fall && bitcnt == 4'd8) begin
                        bitcnt <= '0;
                        if (state == ST_ADDR) begin
                            if (shreg[7:1] == DEV_ADDR) begin
                                is_read <= shreg[0];
                                sda_oe  <= 1'b1;
                                state   <= ST_ACK;
                            end else begin
                                state <= ST_SKIP;
                            end
                        end else begin
                            case (phase)
                                PH_INDEX: begin
                                    idx    <= shreg;
                                    phase  <= PH_COUNT;
                                    sda_oe <= 1'b1;
                                    state  <= ST_ACK;
                                end
                                PH_COUNT: begin
                                    left   <= shreg;
                                    phase  <= PH_DATA;
                                    sda_oe <= 1'b1;
                                    state  <= ST_ACK;
                                end
                                default: begin
                                    if (left != 8'd0) begin
                                        wr_en   <= 1'b1;
                                        wr_idx  <= idx;
                                        wr_data <= shreg;
                                        idx     <= idx + 1'b1;
                                        left    <= left - 8'd1;
                                        sda_oe  <= 1'b1;
                                        state   <= ST_ACK;
                                    end else begin
                                        state <= ST_SKIP;
                                    end
                                end
                            endcase
                        end
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        if (is_read) begin
                            shreg  <= cnt_byte;
                            sda_oe <= ~cnt_byte[7];
                            bitcnt <= '0;
                            state  <= ST_RDATA;
                        end else begin
                            sda_oe <= 1'b0;
                            state  <= ST_WDATA;
                        end
                    end
                end
                ST_RDATA: begin
                    if (scl_fall) begin
                        if (bitcnt == 4'd7) begin
                            sda_oe <= 1'b0;
                            state  <= ST_RACK;
                        end else begin
                            shreg  <= {shreg[6:0], 1'b0};
                            sda_oe <= ~shreg[6];
                            bitcnt <= bitcnt + 4'd1;
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise) begin
                        host_ack <= ~sda_lvl;
                    end else if (scl_fall) begin
                        if (host_ack) begin
                            shreg  <= rd_data;
                            sda_oe <= ~rd_data[7];
                            idx    <= idx + 1'b1;
                            bitcnt <= '0;
                            state  <= ST_RDATA;
                        end else begin
                            state <= ST_SKIP;
                        end
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/smb_reg_bank.sv
module smb_reg_bank
    import smb_clkgen_pkg::*;
#(
    parameter logic [7:0] VENDOR_REV = 8'h01,
    parameter logic [7:0] DEVICE_ID  = 8'h08
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [4:0]       straps,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [7:0]       wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [7:0]       rd_data,
    output logic [7:0]       cnt_byte,
    output ctl0_t            ctl0,
    output logic [7:0]       out_en,
    output logic [7:0]       stop_able,
    output mode_t            mode
);
    logic [7:0] bank [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        localparam logic [7:0] MASK = write_mask(g);
        logic [7:0] q;
        logic       hit;
        assign hit     = wr_en && (wr_idx == IDX_W'(g));
        assign bank[g] = q;
        if (g == B_CTL) begin : g_ctl
            always_ff @(posedge clk) begin
                if (rst)
                    q <= reset_value(g, straps, VENDOR_REV, DEVICE_ID);
                else if (hit)
                    q <= q[2] ? wr_data : {q[7:3], wr_data[2:0]};
            end
        end else begin : g_plain
            always_ff @(posedge clk) begin
                if (rst)
                    q <= reset_value(g, straps, VENDOR_REV, DEVICE_ID);
                else if (hit)
                    q <= (q & ~MASK) | (wr_data & MASK);
            end
        end
    end

    always_comb begin
        rd_data = 8'h00;
        for (int g = 0; g < NUM_REGS; g++) begin
            if (rd_idx == IDX_W'(g))
                rd_data = bank[g] | ((g == B_STRAP) ? {straps, 3'b000} : 8'h00);
        end
    end

    assign cnt_byte  = bank[B_COUNT];
    assign ctl0      = ctl0_t'(bank[B_CTL]);
    assign out_en    = bank[B_OUTEN];
    assign stop_able = bank[B_STOP];
    assign mode      = mode_t'(bank[B_MODE]);
endmodule

// File: rtl/smb_clkgen_regs.sv
module smb_clkgen_regs
    import smb_clkgen_pkg::*;
#(
    parameter int         SYNC_STAGES = 2,
    parameter logic [6:0] DEV_ADDR    = 7'h6E,
    parameter logic [7:0] VENDOR_REV  = 8'h01,
    parameter logic [7:0] DEVICE_ID   = 8'h08
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    input  logic [3:0] strap_fs,
    input  logic       strap_spread,
    output logic [3:0] freq_sel,
    output logic       spread_en,
    output logic       spread_center,
    output logic       stop_hiz,
    output logic [7:0] out_en,
    output logic [7:0] stop_able,
    output logic       mn_prog_en,
    output logic       oe_pol,
    output logic       ref_en
);
    logic [1:0] line_in, line_lvl, line_rise, line_fall;
    assign line_in = {sda_i, scl_i};

    for (genvar l = 0; l < 2; l++) begin : g_sync
        smb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk     (clk),
            .rst     (rst),
            .line_i  (line_in[l]),
            .level_o (line_lvl[l]),
            .rise_o  (line_rise[l]),
            .fall_o  (line_fall[l])
        );
    end

    logic scl_s, sda_s, sda_rise;
    assign scl_s    = line_lvl[0];
    assign sda_s    = line_lvl[1];
    assign sda_rise = line_rise[1];

    logic             wr_en;
    logic [IDX_W-1:0] wr_idx, rd_idx;
    logic [7:0]       wr_data, rd_data, cnt_byte;
    ctl0_t            ctl0;
    mode_t            mode;
    logic             sw_ovr;

    smb_proto_engine #(.DEV_ADDR(DEV_ADDR)) u_engine (
        .clk      (clk),
        .rst      (rst),
        .scl_lvl  (scl_s),
        .scl_rise (line_rise[0]),
        .scl_fall (line_fall[0]),
        .sda_lvl  (sda_s),
        .sda_rise (sda_rise),
        .sda_fall (line_fall[1]),
        .rd_data  (rd_data),
        .cnt_byte (cnt_byte),
        .sda_oe   (sda_oe),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_data  (wr_data),
        .rd_idx   (rd_idx)
    );

    smb_reg_bank #(.VENDOR_REV(VENDOR_REV), .DEVICE_ID(DEVICE_ID)) u_bank (
        .clk       (clk),
        .rst       (rst),
        .straps    ({strap_fs, strap_spread}),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data),
        .rd_idx    (rd_idx),
        .rd_data   (rd_data),
        .cnt_byte  (cnt_byte),
        .ctl0      (ctl0),
        .out_en    (out_en),
        .stop_able (stop_able),
        .mode      (mode)
    );

    assign freq_sel      = ctl0.freq_sel;
    assign spread_en     = ctl0.spread_en;
    assign sw_ovr        = ctl0.sw_ovr;
    assign stop_hiz      = ctl0.stop_hiz;
    assign spread_center = ctl0.spread_center;
    assign mn_prog_en    = mode.mn_prog_en;
    assign oe_pol        = mode.oe_pol;
    assign ref_en        = mode.ref_en;
endmodule

// File: rtl/smb_clkgen_regs_chk.sv
module smb_clkgen_regs_chk
    import smb_clkgen_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             scl_s,
    input logic             sda_rise,
    input logic             sda_oe,
    input logic             wr_en,
    input logic [IDX_W-1:0] wr_idx,
    input logic             sw_ovr,
    input logic [3:0]       freq_sel,
    input logic [7:0]       out_en,
    input logic [7:0]       stop_able
);
    // R11: a stop seen on the synchronised lines leaves SDA released
    p_stop_release_r11: assert property (@(posedge clk) disable iff (rst)
        (sda_rise && scl_s) |=> !sda_oe);

    // R11: the slave pulls SDA low only after SCL was seen low
    p_sda_low_phase_r11: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe) |-> (!$past(scl_s) || !sda_oe));

    // R2: the enable byte only moves after a bus write to index 1
    p_outen_by_write_r2: assert property (@(posedge clk) disable iff (rst)
        !$stable(out_en) |-> $past(wr_en && wr_idx == IDX_W'(B_OUTEN)));

    // R6: strap-loaded bits move only through a write with override already set
    p_strap_lock_r6: assert property (@(posedge clk) disable iff (rst)
        !$stable(freq_sel) |-> $past(wr_en && wr_idx == IDX_W'(B_CTL) && sw_ovr));

    // R5: reset leaves all outputs enabled and free-running
    p_reset_state_r5: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (out_en == 8'hFF && stop_able == 8'h00));
endmodule

bind smb_clkgen_regs smb_clkgen_regs_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .scl_s     (scl_s),
    .sda_rise  (sda_rise),
    .sda_oe    (sda_oe),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .sw_ovr    (sw_ovr),
    .freq_sel  (freq_sel),
    .out_en    (out_en),
    .stop_able (stop_able)
);

// File: tb/tb_smb_clkgen_regs.sv
module tb_smb_clkgen_regs;
    localparam int Q = 8;
    localparam int H = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic scl_h = 1'b1, sda_h = 1'b1;
    logic sda_oe, sda_bus;
    logic [3:0] strap_fs;
    logic strap_spread;
    logic [3:0] freq_sel;
    logic spread_en, spread_center, stop_hiz, mn_prog_en, oe_pol, ref_en;
    logic [7:0] out_en, stop_able;

    assign sda_bus = sda_h & ~sda_oe;

    smb_clkgen_regs dut (
        .clk(clk), .rst(rst), .scl_i(scl_h), .sda_i(sda_bus), .sda_oe(sda_oe),
        .strap_fs(strap_fs), .strap_spread(strap_spread),
        .freq_sel(freq_sel), .spread_en(spread_en), .spread_center(spread_center),
        .stop_hiz(stop_hiz), .out_en(out_en), .stop_able(stop_able),
        .mn_prog_en(mn_prog_en), .oe_pol(oe_pol), .ref_en(ref_en)
    );

    int checks = 0, fails = 0;
    bit finished = 1'b0;
    logic [7:0] model [15];
    logic [7:0] wbuf [8];

    task automatic check8(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_read(int i);
        if (i > 14) return 8'h00;
        if (i == 3) return {strap_fs, strap_spread, 3'b000};
        return model[i];
    endfunction

    task automatic model_write(int i, logic [7:0] v);
        case (i)
            0: model[0] = model[0][2] ? v : {model[0][7:3], v[2:0]};
            1, 2, 6, 10, 11, 12: model[i] = v;
            9: model[9] = v & 8'hE0;
            13: model[13] = v & 8'h7F;
            default: ;
        endcase
    endtask

    task automatic model_reset();
        for (int i = 0; i < 15; i++) model[i] = 8'h00;
        model[0] = {strap_fs, strap_spread, 3'b000};
        model[1] = 8'hFF; model[4] = 8'h01; model[5] = 8'h08;
        model[6] = 8'h07; model[9] = 8'h60; model[14] = 8'h80;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_h = 1'b1; idle(Q); scl_h = 1'b1; idle(H);
        sda_h = 1'b0; idle(H); scl_h = 1'b0; idle(Q);
    endtask

    task automatic bus_stop();
        sda_h = 1'b0; idle(Q); scl_h = 1'b1; idle(H); sda_h = 1'b1; idle(H);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic nack);
        for (int i = 7; i >= 0; i--) begin
            sda_h = b[i]; idle(Q); scl_h = 1'b1; idle(H); scl_h = 1'b0; idle(Q);
        end
        sda_h = 1'b1; idle(Q); scl_h = 1'b1; idle(H/2);
        nack = sda_bus; idle(H/2); scl_h = 1'b0; idle(Q);
    endtask

    task automatic recv_byte(input logic ack, output logic [7:0] b);
        sda_h = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            idle(Q); scl_h = 1'b1; idle(H/2); b[i] = sda_bus; idle(H/2); scl_h = 1'b0;
        end
        idle(Q); sda_h = ~ack; idle(Q); scl_h = 1'b1; idle(H); scl_h = 1'b0; idle(Q);
        sda_h = 1'b1;
    endtask

    task automatic block_write(int idx, int cnt, int nbytes);
        logic nk;
        bus_start();
        send_byte(8'hDC, nk); check8("R1 write address ACK", {7'd0, nk}, 8'h00);
        send_byte(idx[7:0], nk); check8("R2 index ACK", {7'd0, nk}, 8'h00);
        send_byte(cnt[7:0], nk); check8("R2 count ACK", {7'd0, nk}, 8'h00);
        for (int k = 0; k < nbytes; k++) begin
            send_byte(wbuf[k], nk);
            if (k < cnt) begin
                check8((idx + k > 14) ? "R9 out-of-range write ACK" : "R2 data ACK",
                       {7'd0, nk}, 8'h00);
                model_write(idx + k, wbuf[k]);
            end else begin
                check8("R3 surplus byte NACK", {7'd0, nk}, 8'h01);
            end
            if (nk) break;
        end
        bus_stop(); idle(4);
        check8("R11 SDA released after stop", {7'd0, sda_oe}, 8'h00);
    endtask

    task automatic block_read(int idx, int n, string tag);
        logic nk;
        logic [7:0] b;
        bus_start();
        send_byte(8'hDC, nk); check8("R1 write address ACK", {7'd0, nk}, 8'h00);
        send_byte(idx[7:0], nk); check8("R4 index ACK", {7'd0, nk}, 8'h00);
        bus_start();
        send_byte(8'hDD, nk); check8("R1 read address ACK", {7'd0, nk}, 8'h00);
        recv_byte(1'b1, b); check8("R4 count byte first", b, model[6]);
        for (int k = 0; k < n; k++) begin
            recv_byte(k != n - 1, b);
            check8($sformatf("%s byte %0d", tag, idx + k), b, exp_read(idx + k));
        end
        idle(2);
        check8("R4 SDA released after host NACK", {7'd0, sda_oe}, 8'h00);
        bus_stop(); idle(4);
    endtask

    task automatic check_outputs(string when);
        check8({"R10 byte0 fields ", when},
               {1'b0, freq_sel, spread_en, stop_hiz, spread_center},
               {1'b0, model[0][7:3], model[0][1:0]});
        check8({"R10 out_en ", when}, out_en, model[1]);
        check8({"R10 stop_able ", when}, stop_able, model[2]);
        check8({"R10 mode bits ", when}, {5'd0, mn_prog_en, oe_pol, ref_en},
               {5'd0, model[9][7:5]});
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic nk;
        int unsigned seed;
        seed = $urandom(32'd4242);
        strap_fs = 4'hB; strap_spread = 1'b1;
        model_reset();
        idle(6); rst = 1'b0; idle(4);

        // R5 reset state at the ports and through a full read
        check8("R5 out_en after reset", out_en, 8'hFF);
        check8("R5 stop_able after reset", stop_able, 8'h00);
        check8("R5 freq_sel from straps", {4'd0, freq_sel}, 8'h0B);
        check_outputs("after reset");
        block_read(0, 15, "R5 reset value");

        // R7 straps change after reset: byte 3 follows, byte 0 keeps its value
        strap_fs = 4'h2; strap_spread = 1'b0; idle(4);
        block_read(3, 1, "R7 live strap byte");
        block_read(0, 1, "R7 byte0 holds reset straps");
        check8("R7 freq_sel unchanged", {4'd0, freq_sel}, 8'h0B);

        // R1 foreign address NACKed, then ignored until next start
        bus_start();
        send_byte(8'hB4, nk); check8("R1 foreign address NACK", {7'd0, nk}, 8'h01);
        send_byte(8'h00, nk); check8("R1 released after NACK", {7'd0, nk}, 8'h01);
        bus_stop(); idle(4);

        // R6 override rule
        wbuf[0] = 8'h53; block_write(0, 1, 1);
        check8("R6 strap bits locked", {4'd0, freq_sel}, 8'h0B);
        wbuf[0] = 8'h74; block_write(0, 1, 1);
        check8("R6 override set alone keeps strap bits", {4'd0, freq_sel}, 8'h0B);
        wbuf[0] = 8'hA5; block_write(0, 1, 1);
        check8("R6 strap bits taken with override", {4'd0, freq_sel}, 8'h0A);
        check_outputs("after override");
        block_read(0, 1, "R6 byte0");

        // R3 surplus byte
        wbuf[0] = 8'h3C; wbuf[1] = 8'hC3; block_write(1, 1, 2);
        block_read(1, 2, "R3 surplus not stored");

        // R8 read-only bytes and reserved bits
        wbuf[0] = 8'hFF; wbuf[1] = 8'hFF; wbuf[2] = 8'hFF;
        block_write(3, 3, 3);
        block_write(7, 3, 3);
        wbuf[0] = 8'hFF; block_write(13, 1, 1);
        block_read(3, 12, "R8 protected byte");

        // R9 beyond the file
        wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33; wbuf[3] = 8'h44;
        block_write(13, 4, 4);
        block_read(12, 5, "R9 out-of-range read");

        // random block writes with periodic full readback
        for (int r = 0; r < 20; r++) begin
            int idx, cnt, nb;
            idx = $urandom_range(0, 16);
            cnt = $urandom_range(1, 4);
            nb  = cnt + (($urandom_range(0, 3) == 0) ? 1 : 0);
            for (int k = 0; k < 8; k++) wbuf[k] = 8'($urandom);
            block_write(idx, cnt, nb);
            check_outputs("random");
            if (r % 7 == 6) block_read(0, 17, "R2 random readback");
        end
        block_read(0, 17, "R2 final readback");

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule